// File: doc/BRIEF.md
# Video Standard Hunting Controller

This block drives a 2-bit select code to an external serial video receiver so that the receiver can find the rate of the incoming stream. While no lock is held and a carrier is present, the block stays on each candidate code for a programmable number of parallel-clock cycles, called the dwell. When the dwell runs out it moves to the next candidate. The word aligner downstream reports each valid timing reference sequence with a one-cycle strobe. The first such strobe freezes the code and raises the locked indication.

Stepping also stops whenever the carrier-detect level is low. In that case the code and the partly used dwell are both held. Once locked, the block watches for further sync strobes. If a programmable number of carrier-present cycles passes with no strobe, the block drops the lock and resumes hunting from the code it holds, starting a fresh dwell.

Code meaning: 00 selects component 4:2:2 at 270 Mb/s, 10 selects composite 4fsc NTSC, 11 selects composite 4fsc PAL. Code 01 is unused.

Top module: `std_hunt_ctrl`

## Requirements
- R1: After reset the select code is 00, the lock indication is low, and the dwell count is cleared.
- R2: With the default skip option, hunting steps through codes in the order 00, 10, 11, 00, and code 01 never appears on the output.
- R3: While unlocked with carrier high, the code advances exactly `hunt_period` cycles after the previous change or after reset. A `hunt_period` of 0 behaves as 1.
- R4: While carrier detect is low, the code holds its value and the dwell count is frozen. When the carrier returns, only the remainder of the dwell is served.
- R5: A sync strobe raises the lock indication on the next cycle. The code stays constant for as long as the lock indication is high.
- R6: While locked with carrier high, `lock_timeout` consecutive cycles without a sync strobe clear the lock indication. Hunting then resumes from the held code with a full dwell.
- R7: While locked, cycles with carrier low neither count toward the timeout nor release the lock.
- R8: A sync strobe while locked restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_ok | input | 1 | Carrier-detect level from the receiver |
| sync_valid | input | 1 | One-cycle strobe for each valid timing reference sequence |
| hunt_period | input | CNT_W | Dwell per code, in clock cycles |
| lock_timeout | input | CNT_W | Sync-free cycles that release the lock |
| sel_code | output | 2 | Standard-select code to the receiver |
| locked | output | 1 | High while the block holds a lock |

## Verification
A corrupted dwell count shows up as a code change that arrives early or late against the arithmetic schedule. The bench samples every cycle, so this appears within one dwell of the fault. A wrong sequencer transition produces an illegal or out-of-order code at the next step. A faulty timeout counter makes the lock indication fall one or more cycles away from the computed release cycle. A counter that fails to freeze under carrier loss also moves that release cycle.

// File: rtl/std_hunt_pkg.sv
package std_hunt_pkg;

   typedef enum logic [1:0] {
      STD_YC_270   = 2'b00,
      STD_SPARE    = 2'b01,
      STD_CMP_NTSC = 2'b10,
      STD_CMP_PAL  = 2'b11
   } std_code_e;

   localparam logic [1:0] STD_RESET_CODE = STD_YC_270;

endpackage

// File: rtl/hunt_timer.sv
module hunt_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         expire
);
   localparam int XW = W + 1;

   if (W < 1) begin : g_bad_width
      $error("hunt_timer: W must be at least 1");
   end

   logic [W-1:0]  cnt_q;
   logic [XW-1:0] cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + XW'(1);
   assign expire  = run && (cnt_inc >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || expire)
         cnt_q <= '0;
      else if (run)
         cnt_q <= cnt_q + W'(1);
   end

   // R4: a stopped timer keeps its count
   assert_timer_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/hunt_seq.sv
module hunt_seq
   import std_hunt_pkg::*;
#(
   parameter bit SKIP_UNUSED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   output logic [1:0] code
);
   logic [1:0] code_q;
   logic [1:0] code_nx;

   if (SKIP_UNUSED) begin : g_skip
      always_comb begin
         unique case (code_q)
            STD_YC_270:   code_nx = STD_CMP_NTSC;
            STD_CMP_NTSC: code_nx = STD_CMP_PAL;
            default:      code_nx = STD_YC_270;
         endcase
      end

      // R2: the unused code never leaves the block
      assert_no_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
         code_q != STD_SPARE);
   end else begin : g_binary
      assign code_nx = code_q + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         code_q <= STD_RESET_CODE;
      else if (step)
         code_q <= code_nx;
   end

   assign code = code_q;

   // R2: a code only changes when a step was requested
   assert_step_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(code_q));

endmodule

// File: rtl/std_hunt_ctrl.sv
module std_hunt_ctrl #(
   parameter int CNT_W       = 16,
   parameter bit SKIP_UNUSED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             carrier_ok,
   input  logic             sync_valid,
   input  logic [CNT_W-1:0] hunt_period,
   input  logic [CNT_W-1:0] lock_timeout,
   output logic [1:0]       sel_code,
   output logic             locked
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("std_hunt_ctrl: CNT_W must be at least 2");
   end

   logic locked_q;
   logic dwell_run, dwell_clr, dwell_done;
   logic miss_run, miss_clr, miss_done;

   assign dwell_run = !locked_q && carrier_ok && !sync_valid;
   assign dwell_clr = sync_valid || miss_done;
   assign miss_run  = locked_q && carrier_ok && !sync_valid;
   assign miss_clr  = sync_valid || !locked_q;

   hunt_timer #(.W(CNT_W)) u_dwell (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (dwell_run),
      .clr    (dwell_clr),
      .limit  (hunt_period),
      .expire (dwell_done)
   );

   hunt_timer #(.W(CNT_W)) u_miss (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (miss_run),
      .clr    (miss_clr),
      .limit  (lock_timeout),
      .expire (miss_done)
   );

   hunt_seq #(.SKIP_UNUSED(SKIP_UNUSED)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (dwell_done),
      .code  (sel_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         locked_q <= 1'b0;
      else if (sync_valid)
         locked_q <= 1'b1;
      else if (miss_done)
         locked_q <= 1'b0;
   end

   assign locked = locked_q;

   assert_hold_no_carrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> $stable(sel_code));

   assert_lock_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_valid |=> locked);

   assert_hold_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(sel_code));

   assert_release_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> ($past(carrier_ok) && !$past(sync_valid)));

   assert_keep_lock_no_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !carrier_ok) |=> locked);

endmodule

// File: tb/std_hunt_ctrl_bench.sv
module std_hunt_ctrl_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         carrier_ok = 1'b0;
   logic         sync_valid = 1'b0;
   logic [W-1:0] hunt_period = '0;
   logic [W-1:0] lock_timeout = '0;
   logic [1:0]   sel_code;
   logic         locked;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   std_hunt_ctrl #(.CNT_W(W), .SKIP_UNUSED(1'b1)) u_std_hunt_ctrl (
      .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .sync_valid(sync_valid),
      .hunt_period(hunt_period), .lock_timeout(lock_timeout),
      .sel_code(sel_code), .locked(locked)
   );

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input string req, input logic [1:0] exp_code, input logic exp_lock);
      n_tests++;
      if (sel_code !== exp_code || locked !== exp_lock) begin
         n_fail++;
         $display("FAIL %s: code=%b locked=%b expected code=%b locked=%b at %0t",
                  req, sel_code, locked, exp_code, exp_lock, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sync_valid = 1'b0;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic pulse_sync();
      sync_valid = 1'b1;
      cyc(1);
      sync_valid = 1'b0;
   endtask

   function automatic logic [1:0] sched(input int t, input int pe);
      int idx;
      idx = (t / pe) % 3;
      return (idx == 0) ? 2'b00 : (idx == 1) ? 2'b10 : 2'b11;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int T;
      int P;
      T = 6;
      P = 3;
      @(posedge clk);
      #2;
      do_reset();
      chk("R1 reset", 2'b00, 1'b0);

      // R2, R3: sweep dwell settings, check every cycle against the schedule
      for (int p = 0; p <= 6; p++) begin
         int pe;
         pe = (p == 0) ? 1 : p;
         hunt_period = W'(p);
         carrier_ok = 1'b1;
         do_reset();
         chk("R1 reset before sweep", 2'b00, 1'b0);
         for (int t = 1; t <= 3 * pe + 2; t++) begin
            cyc(1);
            chk("R2/R3 hunt schedule", sched(t, pe), 1'b0);
         end
      end

      // R4: carrier loss freezes code and partial dwell
      hunt_period = W'(4);
      carrier_ok = 1'b1;
      do_reset();
      cyc(2);
      carrier_ok = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cyc(1);
         chk("R4 hold on carrier loss", 2'b00, 1'b0);
      end
      carrier_ok = 1'b1;
      cyc(1);
      chk("R4 remaining dwell", 2'b00, 1'b0);
      cyc(1);
      chk("R4 resume step", 2'b10, 1'b0);

      // R5, R6: lock, hold, release, resume with full dwell
      hunt_period = W'(P);
      lock_timeout = W'(T);
      do_reset();
      cyc(4);
      chk("R3 pre-lock code", 2'b10, 1'b0);
      pulse_sync();
      chk("R5 lock after sync", 2'b10, 1'b1);
      cyc(T - 1);
      chk("R5 code held while locked", 2'b10, 1'b1);
      cyc(1);
      chk("R6 release on timeout", 2'b10, 1'b0);
      cyc(P - 1);
      chk("R6 full dwell after release", 2'b10, 1'b0);
      cyc(1);
      chk("R6 hunting resumed", 2'b11, 1'b0);

      // R8: sync while locked restarts timeout
      pulse_sync();
      chk("R5 relock", 2'b11, 1'b1);
      cyc(3);
      pulse_sync();
      cyc(T - 1);
      chk("R8 timeout restarted", 2'b11, 1'b1);
      cyc(1);
      chk("R8 release after restarted timeout", 2'b11, 1'b0);

      // R7: carrier loss while locked pauses the timeout
      pulse_sync();
      cyc(2);
      carrier_ok = 1'b0;
      for (int i = 0; i < 10; i++) begin
         cyc(1);
         chk("R7 lock kept without carrier", 2'b11, 1'b1);
      end
      carrier_ok = 1'b1;
      cyc(T - 3);
      chk("R7 timeout paused", 2'b11, 1'b1);
      cyc(1);
      chk("R7 release after paused timeout", 2'b11, 1'b0);
      cyc(P);
      chk("R2 wrap to first code", 2'b00, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule